// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-line general-purpose I/O port reached through a small register bus. Software sets the direction of each line and reads or writes a shared data register. The data register is reached through a 1 KiB address window, and the word address inside that window acts as a per-bit mask. With this mask, one access can touch any subset of lines, and no read-modify-write is needed.

Each pad output is a registered value built from three sources. A line set as an output drives its data bit. An input line with a pull-up shows 1, and one with a pull-down shows 0. An input line with neither pull keeps the value it showed last. Input lines copy the external pin level into the data register on every clock. A one-cycle strobe marks each line whose resolved pad value has just changed. The pull configuration is fixed by parameters, and no line may have both pulls set.

Top module: `gpio_masked_port`

## Requirements
- R1: A read at a byte address below 0x400 returns, on the cycle after the request, the data register ANDed with address bits [9:2], zero-extended to 32 bits.
- R2: A write at a byte address below 0x400 changes only the data bits that are set in both address bits [9:2] and the direction register. Every other data bit keeps its value.
- R3: The direction register sits at byte address 0x400, where 1 marks an output. Only write-data bits [7:0] are stored, and a read returns them zero-extended.
- R4: On an output line, the pad output equals the data bit of the previous cycle.
- R5: On an input line whose pull-up bit is set, the pad output is 1. On an input line whose pull-down bit is set, the pad output is 0.
- R6: An input line with neither pull keeps its pad value from the previous cycle, whatever the pin level does.
- R7: On an input line, the pin level is copied into the data bit on every clock. On an output line, the pin level has no effect on the data bit.
- R8: A synchronous reset clears the data and direction registers and the read data, sets the pad outputs to the pull-up mask, and clears the change strobes.
- R9: The change strobe of a line is high for exactly the cycle in which that line's pad output differs from its value in the cycle before.
- R10: A read at any address other than the data window or 0x400 returns 0. A write there changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Register access request |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request, 0 otherwise |
| pin_in | input | 8 | External pin levels |
| pad_out | output | 8 | Resolved pad outputs |
| pad_chg | output | 8 | One-cycle change strobe per line |

## Verification
Every cycle, the assertions check how the pads follow the data and direction registers: output lines track data, floating input lines hold their value, and the change strobes match the pad difference. They also check that output-line data moves only under a data write, that masked reads return the right value, that undefined reads return zero, and the values right after reset. The bench scenarios cover what needs a history of accesses: the value a floating line keeps after switching from output to input, how direction-masked and address-masked writes combine, and how the pull-up and pull-down parameters resolve input lines.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // Window of data-register aliases: 4 bytes per mask combination.
  function automatic int unsigned data_window_bytes(int unsigned nlines);
    return 32'd1 << (nlines + 2);
  endfunction
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode #(
  parameter int NLINES = 8,
  parameter int ADDR_W = 12
) (
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_data,
  output logic              wr_dir,
  output logic              rd_data,
  output logic              rd_dir,
  output logic [NLINES-1:0] addr_mask
);
  localparam int MASK_LO = 2;
  localparam int MASK_HI = NLINES + 1;
  localparam logic [ADDR_W-1:0] DIR_OFS =
    ADDR_W'(gpio_port_pkg::data_window_bytes(NLINES));

  logic in_window;
  logic at_dir;

  always_comb begin
    in_window = (bus_addr[ADDR_W-1:MASK_HI+1] == '0);
    at_dir    = (bus_addr == DIR_OFS);
    addr_mask = bus_addr[MASK_HI:MASK_LO];
    wr_data   = bus_valid &  bus_we & in_window;
    rd_data   = bus_valid & ~bus_we & in_window;
    wr_dir    = bus_valid &  bus_we & at_dir;
    rd_dir    = bus_valid & ~bus_we & at_dir;
  end
endmodule

// File: rtl/gpio_line_regs.sv
module gpio_line_regs #(
  parameter int NLINES = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic              wr_dir,
  input  logic              rd_data,
  input  logic              rd_dir,
  input  logic [NLINES-1:0] addr_mask,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] data_q,
  output logic [NLINES-1:0] dir_q,
  output logic [DATA_W-1:0] rdata
);
  logic [NLINES-1:0] wmask;
  logic [NLINES-1:0] data_d;

  always_comb begin
    wmask  = wr_data ? (addr_mask & dir_q) : '0;
    // Output lines: keep or take masked write; input lines: follow pin.
    data_d = (data_q & dir_q & ~wmask)
           | (wdata[NLINES-1:0] & wmask)
           | (pin_in & ~dir_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      rdata  <= '0;
    end else begin
      data_q <= data_d;
      if (wr_dir) dir_q <= wdata[NLINES-1:0];
      if (rd_data)     rdata <= DATA_W'(data_q & addr_mask);
      else if (rd_dir) rdata <= DATA_W'(dir_q);
      else             rdata <= '0;
    end
  end
endmodule

// File: rtl/gpio_pad_resolve.sv
module gpio_pad_resolve #(
  parameter int                NLINES      = 8,
  parameter logic [NLINES-1:0] PULLUP_MASK = '1,
  parameter logic [NLINES-1:0] PULLDN_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] data_q,
  input  logic [NLINES-1:0] dir_q,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_chg
);
  localparam logic [NLINES-1:0] FLOAT_MASK = ~(PULLUP_MASK | PULLDN_MASK);

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic pad_r;
    logic chg_r;
    logic pad_n;

    // Variant per line chosen by the pull parameters.
    if (PULLUP_MASK[i]) begin : g_up
      assign pad_n = dir_q[i] ? data_q[i] : 1'b1;
    end else if (FLOAT_MASK[i]) begin : g_hold
      assign pad_n = dir_q[i] ? data_q[i] : pad_r;
    end else begin : g_down
      assign pad_n = dir_q[i] ? data_q[i] : 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_r <= PULLUP_MASK[i];
        chg_r <= 1'b0;
      end else begin
        pad_r <= pad_n;
        chg_r <= pad_n ^ pad_r;
      end
    end

    assign pad_out[i] = pad_r;
    assign pad_chg[i] = chg_r;
  end
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port #(
  parameter int          NLINES      = 8,
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter logic [7:0]  PULLUP_MASK = 8'hFF,
  parameter logic [7:0]  PULLDN_MASK = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_chg
);
  logic              wr_data, wr_dir, rd_data, rd_dir;
  logic [NLINES-1:0] addr_mask;
  logic [NLINES-1:0] data_q;
  logic [NLINES-1:0] dir_q;

  gpio_bus_decode #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_dec (
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wr_data   (wr_data),
    .wr_dir    (wr_dir),
    .rd_data   (rd_data),
    .rd_dir    (rd_dir),
    .addr_mask (addr_mask)
  );

  gpio_line_regs #(.NLINES(NLINES), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_data   (wr_data),
    .wr_dir    (wr_dir),
    .rd_data   (rd_data),
    .rd_dir    (rd_dir),
    .addr_mask (addr_mask),
    .wdata     (bus_wdata),
    .pin_in    (pin_in),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .rdata     (bus_rdata)
  );

  gpio_pad_resolve #(
    .NLINES      (NLINES),
    .PULLUP_MASK (NLINES'(PULLUP_MASK)),
    .PULLDN_MASK (NLINES'(PULLDN_MASK))
  ) u_pad (
    .clk     (clk),
    .rst     (rst),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .pad_out (pad_out),
    .pad_chg (pad_chg)
  );
endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
  parameter int          NLINES      = 8,
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter logic [7:0]  PULLUP_MASK = 8'hFF,
  parameter logic [7:0]  PULLDN_MASK = 8'h00
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NLINES-1:0] pad_out,
  input logic [NLINES-1:0] pad_chg,
  input logic [NLINES-1:0] data_q,
  input logic [NLINES-1:0] dir_q
);
  localparam logic [NLINES-1:0] FLOAT = ~NLINES'(PULLUP_MASK | PULLDN_MASK);
  localparam logic [ADDR_W-1:0] DIRA  =
    ADDR_W'(gpio_port_pkg::data_window_bytes(NLINES));

  logic in_win;
  assign in_win = (bus_addr < DIRA);

  // R8: state right after reset
  assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_out == NLINES'(PULLUP_MASK)) && (pad_chg == '0) && (bus_rdata == '0));

  // R9: strobe marks pad difference
  assert_chg_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pad_chg == (pad_out ^ $past(pad_out)));

  // R4: output lines follow data
  assert_out_follow_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pad_out ^ $past(data_q)) & $past(dir_q)) == '0);

  // R6: floating inputs hold
  assert_float_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pad_out ^ $past(pad_out)) & ~$past(dir_q) & FLOAT) == '0);

  // R7: output-line data moves only under a data write
  assert_out_data_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_valid && bus_we && in_win))
      |-> ((data_q ^ $past(data_q)) & $past(dir_q)) == '0);

  // R1: masked read
  assert_masked_read_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we && in_win)
      |=> bus_rdata == DATA_W'($past(data_q) & $past(bus_addr[NLINES+1:2])));

  // R10: undefined offsets read as zero
  assert_undef_read_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we && !in_win && bus_addr != DIRA) |=> bus_rdata == '0);
endmodule

bind gpio_masked_port gpio_masked_port_chk #(
  .NLINES(NLINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .PULLUP_MASK(PULLUP_MASK), .PULLDN_MASK(PULLDN_MASK)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pad_out(pad_out),
  .pad_chg(pad_chg), .data_q(data_q), .dir_q(dir_q)
);

// File: tb/tb_gpio_masked_port.sv
module tb_gpio_masked_port;
  localparam int         CLK_PERIOD = 10;
  localparam logic [7:0] PU = 8'h0F;
  localparam logic [7:0] PD = 8'h30;
  localparam logic [7:0] FL = ~(PU | PD);
  localparam int         NVEC = 6;
  // {dir, addr mask, write data, pins}
  localparam logic [31:0] VEC [NVEC] = '{
    32'hFF_FF_A5_00, 32'hF0_FF_3C_5A, 32'h00_FF_FF_C3,
    32'h0F_0A_FF_FF, 32'hFF_81_00_00, 32'h3C_FF_99_66
  };

  logic        clk = 0;
  logic        rst = 1;
  logic        bus_valid = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pad_out, pad_chg;

  int errors = 0;
  int checks = 0;
  logic [7:0]  mdata, mdir, mpad, odir, wm;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_masked_port #(.PULLUP_MASK(PU), .PULLDN_MASK(PD)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_out(pad_out), .pad_chg(pad_chg)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic rdr(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8: reset state
    chk("R8 pad after reset", pad_out, PU);
    chk("R8 chg after reset", pad_chg, 0);
    rdr(12'h400, rd); chk("R8 dir after reset", rd, 0);
    rdr(12'h3FC, rd); chk("R8 data after reset", rd, 0);

    mdata = 0; mdir = 0; mpad = PU;
    // Vector table: R1 R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] vd, vm, vw, vp;
      {vd, vm, vw, vp} = VEC[v];
      @(negedge clk); pin_in = vp;
      odir = mdir;
      wr(12'h400, {24'h0, vd});
      mdata = (((mdata & odir) | (vp & ~odir)) & vd) | (vp & ~vd);
      mdir = vd;
      wr({2'b00, vm, 2'b00}, {24'h0, vw});
      wm = vm & mdir;
      mdata = (mdata & ~wm) | (vw & wm);
      repeat (2) @(negedge clk);
      mpad = (mdata & mdir) | (PU & ~mdir) | (mpad & FL & ~mdir);
      chk("R4/R5/R6 vector pad", pad_out, mpad);
      rdr(12'h3FC, rd); chk("R2/R7 vector full read", rd, {24'h0, mdata});
      rdr({2'b00, vm, 2'b00}, rd); chk("R1 vector masked read", rd, {24'h0, mdata & vm});
    end

    // R6: floating line keeps last output value after turning to input
    @(negedge clk); pin_in = 8'h00;
    wr(12'h400, 32'hFF);
    wr(12'h3FC, 32'hC0);
    repeat (2) @(negedge clk);
    chk("R4 pad drives data", pad_out, 8'hC0);
    wr(12'h400, 32'h00);
    repeat (2) @(negedge clk);
    chk("R5 R6 pulled and held pads", pad_out, 8'hCF);
    pin_in = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R6 hold ignores pins", pad_out, 8'hCF);
    rdr(12'h3FC, rd); chk("R7 input capture", rd, 32'hFF);

    // R9: change strobe
    wr(12'h400, 32'hFF);
    repeat (3) @(negedge clk);
    wr(12'h3FC, 32'h7E);
    @(negedge clk);
    chk("R9 strobe on change", pad_chg, 8'h81);
    chk("R9 pad after change", pad_out, 8'h7E);
    @(negedge clk);
    chk("R9 strobe one cycle", pad_chg, 8'h00);

    // R7: pins ignored on outputs
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    rdr(12'h3FC, rd); chk("R7 pins ignored on outputs", rd, 32'h7E);

    // R2: address-masked write
    wr(12'h03C, 32'h00);
    rdr(12'h3FC, rd); chk("R2 address-masked write", rd, 32'h70);
    wr(12'h400, 32'h0F);
    wr(12'h3FC, 32'hFF);
    rdr(12'h3FC, rd); chk("R2 direction-masked write", rd, 32'h0F);

    // R3: only low byte of direction stored
    wr(12'h400, 32'hFFFF_FF33);
    rdr(12'h400, rd); chk("R3 dir low byte", rd, 32'h33);

    // R10: undefined offsets
    wr(12'h404, 32'hFF);
    rdr(12'h404, rd); chk("R10 undefined read", rd, 0);
    rdr(12'h400, rd); chk("R10 dir untouched", rd, 32'h33);
    rdr(12'h800, rd); chk("R10 high undefined read", rd, 0);

    // R8: reset mid-run
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R8 pad after second reset", pad_out, PU);
    chk("R8 chg after second reset", pad_chg, 0);
    rdr(12'h400, rd); chk("R8 dir after second reset", rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule